// File: doc/BRIEF.md
# Banked Direct Address Resolver

This block sits in the operand decode path of a small 8-bit core. It takes the operand fields of a byte-oriented or bit-oriented instruction and forms the 12-bit data memory address that the instruction targets. It also reports whether the result goes back to that file register or to the accumulator. The 8-bit file literal gives the low byte of the address. The high nibble depends on the addressing mode.

There are three addressing modes. In banked mode the access bit is 1, and the 4-bit bank register is placed above the literal. In access-window mode the access bit is 0. The literal then selects a split window: its low part maps into general RAM at the bottom of memory, and its high part maps into the special function register area at the top. In full-address mode a complete 12-bit operand from the opcode is used as is. The block holds the bank register itself, and the core loads it through a synchronous write port. Address and destination decode are purely combinational.

Top module: `bank_addr_resolver`

## Requirements
- R1: When full_mode_i is 0 and acc_bit_i is 1, addr_o equals {bank_o, file_lit_i}.
- R2: When full_mode_i is 0, acc_bit_i is 0 and file_lit_i is below 60h, addr_o equals {4'h0, file_lit_i}. The bank register has no effect.
- R3: When full_mode_i is 0, acc_bit_i is 0 and file_lit_i is 60h or above, addr_o equals {4'hF, file_lit_i}. This covers F60h to FFFh, and the bank register has no effect.
- R4: When full_mode_i is 1, addr_o equals full_addr_i. The bank register, acc_bit_i and file_lit_i have no effect.
- R5: When implicit_i is 0, dest_file_o equals dest_bit_i. A value of 1 selects the file register and 0 selects the accumulator.
- R6: When implicit_i is 1, dest_file_o equals implicit_file_i, and dest_bit_i has no effect.
- R7: After asynchronous reset the bank register (bank_o) is 0.
- R8: When bank_we_i is 1 at a rising clock edge, bank_o takes the value of bank_d_i. Otherwise bank_o holds its value.
- R9: addr_o and dest_file_o respond in the same cycle the operand fields change, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bank_we_i | input | 1 | Bank register write enable |
| bank_d_i | input | 4 | Bank register write data |
| file_lit_i | input | 8 | Instruction file address literal |
| acc_bit_i | input | 1 | 1 selects banked mode, 0 selects the access window |
| dest_bit_i | input | 1 | Destination field: 1 selects the file register, 0 the accumulator |
| full_mode_i | input | 1 | Use full_addr_i directly |
| full_addr_i | input | 12 | Full 12-bit address operand |
| implicit_i | input | 1 | Instruction has no destination field |
| implicit_file_i | input | 1 | Implicit destination is the file register |
| bank_o | output | 4 | Current bank register |
| addr_o | output | 12 | Effective data memory address |
| dest_file_o | output | 1 | 1 selects the file register as destination, 0 the accumulator |

## Verification
The bank register is the only state in the block. A wrong value in it appears on bank_o one clock after a faulty load. It also corrupts the high nibble of addr_o for every banked access after that, while access-window and full-address results stay correct. The bench therefore loads several bank values and then checks all three modes against each of them. Each check confirms that only banked mode follows the register. It also confirms that decode changes within a cycle, without waiting for a clock.

// File: rtl/bank_addr_pkg.sv
package bank_addr_pkg;
  localparam int unsigned LIT_W  = 8;
  localparam int unsigned BANK_W = 4;
  localparam int unsigned ADDR_W = LIT_W + BANK_W;

  typedef logic [LIT_W-1:0]  lit_t;
  typedef logic [BANK_W-1:0] bank_t;
  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic [1:0] {
    MODE_BANKED = 2'd0,
    MODE_WINDOW = 2'd1,
    MODE_FULL   = 2'd2
  } addr_mode_e;
endpackage

// File: rtl/bar_bank_reg.sv
module bar_bank_reg #(
  parameter int unsigned BANK_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [BANK_W-1:0] d_i,
  output logic [BANK_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/bar_addr_mux.sv
module bar_addr_mux
  import bank_addr_pkg::*;
#(
  parameter int unsigned  LW        = LIT_W,
  parameter int unsigned  BW        = BANK_W,
  parameter logic [LW-1:0] SPLIT    = 8'h60,
  localparam int unsigned AW        = LW + BW
) (
  input  logic [LW-1:0] lit_i,
  input  logic [BW-1:0] bank_i,
  input  logic          acc_bit_i,
  input  logic          full_mode_i,
  input  logic [AW-1:0] full_addr_i,
  output logic [AW-1:0] addr_o
);
  addr_mode_e    mode;
  logic [BW-1:0] win_hi;
  logic [BW-1:0] hi;

  always_comb begin
    if (full_mode_i)    mode = MODE_FULL;
    else if (acc_bit_i) mode = MODE_BANKED;
    else                mode = MODE_WINDOW;
  end

  // window: low part -> bottom of RAM, high part -> SFR region at top
  assign win_hi = (lit_i >= SPLIT) ? {BW{1'b1}} : {BW{1'b0}};

  always_comb begin
    unique case (mode)
      MODE_BANKED: hi = bank_i;
      MODE_WINDOW: hi = win_hi;
      default:     hi = '0;
    endcase
    addr_o = (mode == MODE_FULL) ? full_addr_i : {hi, lit_i};
  end
endmodule

// File: rtl/bar_dest_sel.sv
module bar_dest_sel (
  input  logic dest_bit_i,
  input  logic implicit_i,
  input  logic implicit_file_i,
  output logic dest_file_o
);
  assign dest_file_o = implicit_i ? implicit_file_i : dest_bit_i;
endmodule

// File: rtl/bank_addr_resolver.sv
module bank_addr_resolver
  import bank_addr_pkg::*;
#(
  parameter int unsigned  LW    = LIT_W,
  parameter int unsigned  BW    = BANK_W,
  parameter logic [LW-1:0] SPLIT = 8'h60,
  localparam int unsigned AW    = LW + BW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bank_we_i,
  input  logic [BW-1:0] bank_d_i,
  input  logic [LW-1:0] file_lit_i,
  input  logic          acc_bit_i,
  input  logic          dest_bit_i,
  input  logic          full_mode_i,
  input  logic [AW-1:0] full_addr_i,
  input  logic          implicit_i,
  input  logic          implicit_file_i,
  output logic [BW-1:0] bank_o,
  output logic [AW-1:0] addr_o,
  output logic          dest_file_o
);
  bar_bank_reg #(.BANK_W(BW)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (bank_we_i),
    .d_i    (bank_d_i),
    .q_o    (bank_o)
  );

  bar_addr_mux #(.LW(LW), .BW(BW), .SPLIT(SPLIT)) u_mux (
    .lit_i       (file_lit_i),
    .bank_i      (bank_o),
    .acc_bit_i   (acc_bit_i),
    .full_mode_i (full_mode_i),
    .full_addr_i (full_addr_i),
    .addr_o      (addr_o)
  );

  bar_dest_sel u_dest (
    .dest_bit_i      (dest_bit_i),
    .implicit_i      (implicit_i),
    .implicit_file_i (implicit_file_i),
    .dest_file_o     (dest_file_o)
  );
endmodule

// File: rtl/bank_addr_resolver_chk.sv
module bank_addr_resolver_chk #(
  parameter int unsigned   LW    = 8,
  parameter int unsigned   BW    = 4,
  parameter logic [LW-1:0] SPLIT = 8'h60,
  localparam int unsigned  AW    = LW + BW
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          bank_we_i,
  input logic [BW-1:0] bank_d_i,
  input logic [LW-1:0] file_lit_i,
  input logic          acc_bit_i,
  input logic          dest_bit_i,
  input logic          full_mode_i,
  input logic [AW-1:0] full_addr_i,
  input logic          implicit_i,
  input logic          implicit_file_i,
  input logic [BW-1:0] bank_o,
  input logic [AW-1:0] addr_o,
  input logic          dest_file_o
);
  a_r1_banked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!full_mode_i && acc_bit_i) |-> addr_o == {bank_o, file_lit_i});

  a_r2_window_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!full_mode_i && !acc_bit_i && file_lit_i < SPLIT) |-> addr_o[AW-1:LW] == '0);

  a_r3_window_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!full_mode_i && !acc_bit_i && file_lit_i >= SPLIT) |-> addr_o[AW-1:LW] == '1);

  a_r4_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_mode_i |-> addr_o == full_addr_i);

  a_r5_dest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !implicit_i |-> dest_file_o == dest_bit_i);

  a_r6_implicit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    implicit_i |-> dest_file_o == implicit_file_i);

  a_r8_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bank_we_i |=> bank_o == $past(bank_d_i));

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bank_we_i |=> $stable(bank_o));

  always_comb
    if (!rst_ni) a_r7_reset: assert (bank_o == '0);
endmodule

bind bank_addr_resolver bank_addr_resolver_chk #(.LW(LW), .BW(BW), .SPLIT(SPLIT)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bank_we_i(bank_we_i), .bank_d_i(bank_d_i),
  .file_lit_i(file_lit_i), .acc_bit_i(acc_bit_i), .dest_bit_i(dest_bit_i),
  .full_mode_i(full_mode_i), .full_addr_i(full_addr_i), .implicit_i(implicit_i),
  .implicit_file_i(implicit_file_i), .bank_o(bank_o), .addr_o(addr_o),
  .dest_file_o(dest_file_o)
);

// File: tb/bank_addr_resolver_tb.sv
`timescale 1ns/1ps
module bank_addr_resolver_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bank_we = 1'b0;
  logic [3:0]  bank_d = '0;
  logic [7:0]  lit = '0;
  logic        acc = 1'b0;
  logic        dbit = 1'b0;
  logic        full = 1'b0;
  logic [11:0] faddr = '0;
  logic        impl = 1'b0;
  logic        impl_f = 1'b0;
  logic [3:0]  bank;
  logic [11:0] addr;
  logic        dfile;
  int checks = 0;
  int fails  = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  bank_addr_resolver u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bank_we_i(bank_we), .bank_d_i(bank_d),
    .file_lit_i(lit), .acc_bit_i(acc), .dest_bit_i(dbit), .full_mode_i(full),
    .full_addr_i(faddr), .implicit_i(impl), .implicit_file_i(impl_f),
    .bank_o(bank), .addr_o(addr), .dest_file_o(dfile)
  );

  task automatic chk(string req, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%03h expected=%03h", req, act, exp);
    end
  endtask

  task automatic load_bank(logic [3:0] v);
    @(negedge clk);
    bank_we = 1'b1; bank_d = v;
    @(negedge clk);
    bank_we = 1'b0; bank_d = ~v;
    #1 chk("R8 load", {8'h0, bank}, {8'h0, v});
    @(negedge clk);
    #1 chk("R8 hold", {8'h0, bank}, {8'h0, v});
  endtask

  task automatic set_ops(logic [7:0] l, logic a, logic f, logic [11:0] fa);
    lit = l; acc = a; full = f; faddr = fa;
    #1;
  endtask

  task automatic test_reset();
    #1 chk("R7 reset", {8'h0, bank}, 12'h000);
  endtask

  task automatic test_banked();
    logic [3:0] banks [3] = '{4'h3, 4'hA, 4'hF};
    foreach (banks[i]) begin
      load_bank(banks[i]);
      set_ops(8'h00, 1'b1, 1'b0, 12'h000); chk("R1 banked", addr, {banks[i], 8'h00});
      set_ops(8'hC7, 1'b1, 1'b0, 12'h000); chk("R1 banked", addr, {banks[i], 8'hC7});
      set_ops(8'h5F, 1'b0, 1'b0, 12'h000); chk("R2 window low", addr, 12'h05F);
      set_ops(8'h60, 1'b0, 1'b0, 12'h000); chk("R3 window high", addr, 12'hF60);
      set_ops(8'h12, 1'b1, 1'b1, 12'h8A5); chk("R4 full", addr, 12'h8A5);
    end
  endtask

  task automatic test_window();
    load_bank(4'h7);
    set_ops(8'h00, 1'b0, 1'b0, 12'h000); chk("R2 window low", addr, 12'h000);
    set_ops(8'h2B, 1'b0, 1'b0, 12'h000); chk("R2 window low", addr, 12'h02B);
    set_ops(8'hFF, 1'b0, 1'b0, 12'h000); chk("R3 window high", addr, 12'hFFF);
    set_ops(8'hE7, 1'b0, 1'b0, 12'h000); chk("R3 window high", addr, 12'hFE7);
  endtask

  task automatic test_full();
    set_ops(8'hFF, 1'b0, 1'b1, 12'h123); chk("R4 full", addr, 12'h123);
    set_ops(8'h00, 1'b1, 1'b1, 12'hFFF); chk("R4 full", addr, 12'hFFF);
    set_ops(8'h00, 1'b0, 1'b1, 12'h000); chk("R4 full", addr, 12'h000);
  endtask

  task automatic test_dest();
    impl = 1'b0; dbit = 1'b1; #1 chk("R5 dest file", {11'h0, dfile}, 12'h001);
    dbit = 1'b0; #1 chk("R5 dest accum", {11'h0, dfile}, 12'h000);
    impl = 1'b1; impl_f = 1'b1; dbit = 1'b0; #1 chk("R6 implicit file", {11'h0, dfile}, 12'h001);
    impl_f = 1'b0; dbit = 1'b1; #1 chk("R6 implicit accum", {11'h0, dfile}, 12'h000);
    impl = 1'b0;
  endtask

  task automatic test_comb();
    load_bank(4'h5);
    @(negedge clk);
    set_ops(8'h40, 1'b1, 1'b0, 12'h000); chk("R9 same cycle", addr, 12'h540);
    set_ops(8'h40, 1'b0, 1'b0, 12'h000); chk("R9 same cycle", addr, 12'h040);
  endtask

  initial begin
    #12 test_reset();
    rst_n = 1'b1;
    test_banked();
    test_window();
    test_full();
    test_dest();
    test_comb();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule